// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block sits beside an SMBus target and watches the two bus lines for timing faults that must end a transaction. Both lines first pass through a two-flop synchronizer. The monitor then finds START, repeated START and STOP conditions, and measures every clock-low and clock-high phase in system-clock ticks. Every limit is a tick-count parameter, so the integrator derives it from the system clock period.

Inside one message, from the first START to the STOP, the monitor keeps two cumulative budgets of clock-low time. Low time counts against the local target while its own clock-hold request input is asserted. Otherwise it counts against the controller. The monitor also checks minimum phase lengths, the setup times before repeated START and STOP, and a clock-high idle limit. A select input chooses whether the idle limit is the standard value or one built from two programmable halves.

Any violation sets a sticky error flag and ends the message window. If no flag was pending, it also produces a one-cycle transaction-reset pulse. The surrounding target logic uses that pulse to drop its byte engine back to idle.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset, `in_msg_o`, `xact_rst_o` and all six bits of `err_flags_o` are 0.
- R2: SDA falling while SCL stays high is a START and sets `in_msg_o`. SDA rising while SCL stays high is a STOP and clears it. `in_msg_o` changes on the third rising clock edge after the input change.
- R3: Bit 0 of `err_flags_o` sets when SCL stays low for more than `LOW_TO_T` consecutive ticks, inside or outside a message. A low phase of exactly `LOW_TO_T` ticks does not set it.
- R4: With `hi_sel_i` = 0, bit 1 sets when SCL stays high for more than about `HIGH_STD_T` ticks inside a message. Measurement starts at SCL rising or at the START. Long SCL-high time outside a message sets no flag.
- R5: With `hi_sel_i` = 1, the high limit is the concatenation {`hi_lim_hi_i`, `hi_lim_lo_i`}, and `HIGH_STD_T` is not used.
- R6: Bit 2 sets when the SCL-low ticks counted while `hold_req_i` = 1 add up to more than `SEXT_T` within one message. The sum is cleared by a START that opens a message and kept across a repeated START.
- R7: Bit 3 sets when the SCL-low ticks counted while `hold_req_i` = 0 add up to more than `MEXT_T` within one message.
- R8: Bit 4 sets inside a message when an SCL-low phase is shorter than `LOW_MIN_T` ticks, or an SCL-high phase is shorter than `HIGH_MIN_T` ticks.
- R9: Bit 5 sets when a repeated START follows SCL rising by fewer than `SU_STA_T` ticks, or a STOP follows it by fewer than `SU_STO_T` ticks. A STOP exactly `SU_STO_T` ticks after SCL rising is accepted.
- R10: Error flags stay set until a one-cycle `err_clr_i`. `xact_rst_o` is a single-cycle pulse, raised only for a violation that occurs while no flag is set.
- R11: Any violation clears `in_msg_o` in the same cycle as the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| hold_req_i | input | 1 | Local target is holding the clock low |
| hi_sel_i | input | 1 | 0: standard high limit, 1: programmable high limit |
| hi_lim_hi_i | input | HL_W | Upper half of the programmable high limit |
| hi_lim_lo_i | input | HL_W | Lower half of the programmable high limit |
| err_clr_i | input | 1 | Clears all error flags |
| in_msg_o | output | 1 | A message is open between START and STOP |
| err_flags_o | output | 6 | Sticky flags: 0 low timeout, 1 high timeout, 2 target extension, 3 controller extension, 4 short phase, 5 setup |
| xact_rst_o | output | 1 | One-cycle transaction-reset pulse |

## Verification
A line change passes through two synchronizer flops and is then judged against the previous sample. Every registered result (`in_msg_o`, a flag, the reset pulse) therefore appears on the third rising edge after the edge that captured the input. The bench drives and samples on falling edges, and it waits at least four cycles after each stimulus before it reads a flag or `in_msg_o`. Transaction-reset pulses are counted on every falling edge, so their single-cycle width cannot be missed. Both lines share the synchronizer, so a driven low or high window of N cycles is measured as exactly N ticks. This lets the low-timeout, budget and setup checks sit exactly on their boundaries.

// File: rtl/smb_mon_pkg.sv
`timescale 1ns/1ps
package smb_mon_pkg;

    localparam int NUM_ERR = 6;

    // first field is the most significant bit of the flag vector
    typedef struct packed {
        logic setup;    // bit 5
        logic period;   // bit 4
        logic mext;     // bit 3
        logic sext;     // bit 2
        logic high_to;  // bit 1
        logic low_to;   // bit 0
    } smb_err_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] hold;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d.meta = d_i;
        s_d.hold = s_q.meta;
    end

    // idle bus level is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign q_o = s_q.hold;

endmodule

// File: rtl/smb_cond_detect.sv
`timescale 1ns/1ps
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t p_q, p_d;

    always_comb begin
        p_d.scl = scl_i;
        p_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '1;
        else        p_q <= p_d;
    end

    // data edges count as conditions only when the clock was high on both samples
    assign scl_rise_o = scl_i & ~p_q.scl;
    assign scl_fall_o = ~scl_i & p_q.scl;
    assign start_o    = scl_i & p_q.scl & p_q.sda & ~sda_i;
    assign stop_o     = scl_i & p_q.scl & ~p_q.sda & sda_i;

endmodule

// File: rtl/smb_phase_timer.sv
`timescale 1ns/1ps
module smb_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (run_i && (cnt_q != SAT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/smb_ext_budget.sv
`timescale 1ns/1ps
module smb_ext_budget #(
    parameter int LIM = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic clr_i,
    output logic over_o
);

    localparam int W = $clog2(LIM + 2);
    localparam logic [W-1:0] LIM_C = W'(LIM);
    localparam logic [W-1:0] TOP_C = W'(LIM + 1);

    logic [W-1:0] acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (clr_i)
            acc_d = '0;
        else if (add_i && (acc_q != TOP_C))
            acc_d = acc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // the tick that takes the sum past the budget; saturation keeps it a single event
    assign over_o = add_i & ~clr_i & (acc_q == LIM_C);

endmodule

// File: rtl/smbus_timeout_mon.sv
`timescale 1ns/1ps
module smbus_timeout_mon
    import smb_mon_pkg::*;
#(
    parameter int HL_W       = 8,
    parameter int LOW_TO_T   = 3_000_000,
    parameter int HIGH_STD_T = 5_000,
    parameter int SEXT_T     = 2_500_000,
    parameter int MEXT_T     = 1_000_000,
    parameter int LOW_MIN_T  = 470,
    parameter int HIGH_MIN_T = 400,
    parameter int SU_STA_T   = 470,
    parameter int SU_STO_T   = 400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               hold_req_i,
    input  logic               hi_sel_i,
    input  logic [HL_W-1:0]    hi_lim_hi_i,
    input  logic [HL_W-1:0]    hi_lim_lo_i,
    input  logic               err_clr_i,
    output logic               in_msg_o,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic               xact_rst_o
);

    localparam int LCNT_W = $clog2(LOW_TO_T + 2);
    localparam int HCNT_W = imax(imax($clog2(HIGH_STD_T + 2), 2 * HL_W + 1),
                                 $clog2(imax(SU_STA_T, SU_STO_T) + 2));

    localparam logic [LCNT_W-1:0] LOW_TO_C   = LCNT_W'(LOW_TO_T);
    localparam logic [LCNT_W-1:0] LOW_MIN_C  = LCNT_W'(LOW_MIN_T);
    localparam logic [HCNT_W-1:0] HI_STD_C   = HCNT_W'(HIGH_STD_T);
    localparam logic [HCNT_W-1:0] HIGH_MIN_C = HCNT_W'(HIGH_MIN_T);
    localparam logic [HCNT_W-1:0] SU_STA_C   = HCNT_W'(SU_STA_T);
    localparam logic [HCNT_W-1:0] SU_STO_C   = HCNT_W'(SU_STO_T);

    typedef struct packed {
        logic     in_msg;
        smb_err_t err;
        logic     xact_rst;
    } mon_state_t;

    mon_state_t st_q, st_d;

    logic [1:0]        raw_lines, sync_lines;
    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic [LCNT_W-1:0] low_cnt;
    logic [HCNT_W-1:0] high_cnt;
    logic [HCNT_W-1:0] hi_lim;
    logic [1:0]        bud_add, bud_over;
    logic              bud_clr;
    smb_err_t          viol;

    assign raw_lines = {scl_i, sda_i};

    smb_line_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lines),
        .q_o   (sync_lines)
    );

    assign scl_s = sync_lines[1];
    assign sda_s = sync_lines[0];

    smb_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    smb_phase_timer #(.W(LCNT_W)) u_low_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (~scl_s),
        .clr_i (scl_s),
        .cnt_o (low_cnt)
    );

    // high time restarts at a START or STOP so that idle time does not count
    smb_phase_timer #(.W(HCNT_W)) u_high_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (scl_s),
        .clr_i (~scl_s | start_ev | stop_ev),
        .cnt_o (high_cnt)
    );

    // index 0: local target holding the clock, index 1: controller
    assign bud_add[0] = st_q.in_msg & ~scl_s & hold_req_i;
    assign bud_add[1] = st_q.in_msg & ~scl_s & ~hold_req_i;
    assign bud_clr    = start_ev & ~st_q.in_msg;   // a repeated START keeps the sums

    for (genvar g = 0; g < 2; g++) begin : g_budget
        if (g == 0) begin : g_tgt
            smb_ext_budget #(.LIM(SEXT_T)) u_bud (
                .clk    (clk),
                .rst_n  (rst_n),
                .add_i  (bud_add[g]),
                .clr_i  (bud_clr),
                .over_o (bud_over[g])
            );
        end else begin : g_ctl
            smb_ext_budget #(.LIM(MEXT_T)) u_bud (
                .clk    (clk),
                .rst_n  (rst_n),
                .add_i  (bud_add[g]),
                .clr_i  (bud_clr),
                .over_o (bud_over[g])
            );
        end
    end

    always_comb begin
        hi_lim = hi_sel_i ? HCNT_W'({hi_lim_hi_i, hi_lim_lo_i}) : HI_STD_C;

        viol         = '0;
        viol.low_to  = ~scl_s & (low_cnt == LOW_TO_C);
        viol.high_to = st_q.in_msg & scl_s & (high_cnt == hi_lim);
        viol.sext    = bud_over[0];
        viol.mext    = bud_over[1];
        viol.period  = st_q.in_msg &
                       ((scl_rise & (low_cnt < LOW_MIN_C)) |
                        (scl_fall & (high_cnt < HIGH_MIN_C)));
        viol.setup   = st_q.in_msg &
                       ((start_ev & (high_cnt < SU_STA_C)) |
                        (stop_ev & (high_cnt < SU_STO_C)));

        st_d = st_q;
        if (err_clr_i)
            st_d.err = '0;
        st_d.err      = st_d.err | viol;
        st_d.xact_rst = (|viol) & (st_q.err == '0);

        if (|viol)
            st_d.in_msg = 1'b0;
        else if (start_ev)
            st_d.in_msg = 1'b1;
        else if (stop_ev)
            st_d.in_msg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_msg_o    = st_q.in_msg;
    assign err_flags_o = st_q.err;
    assign xact_rst_o  = st_q.xact_rst;

endmodule

// File: rtl/smb_mon_checker.sv
`timescale 1ns/1ps
module smb_mon_checker
    import smb_mon_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               start_ev,
    input logic               stop_ev,
    input logic               in_msg_o,
    input logic               err_clr_i,
    input logic               xact_rst_o,
    input logic [NUM_ERR-1:0] err_flags_o
);

    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ev && stop_ev)); // R2

    AST_LOWTO_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags_o[0]) |-> !$past(scl_s)); // R3

    AST_HITO_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags_o[1]) |-> $past(in_msg_o)); // R4

    AST_XRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xact_rst_o |=> !xact_rst_o); // R10

    AST_XRST_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        xact_rst_o |-> ($past(err_flags_o) == '0) && (err_flags_o != '0)); // R10

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o))); // R10

    AST_ABORT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|err_flags_o) |-> !in_msg_o); // R11

endmodule

bind smbus_timeout_mon smb_mon_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .in_msg_o    (in_msg_o),
    .err_clr_i   (err_clr_i),
    .xact_rst_o  (xact_rst_o),
    .err_flags_o (err_flags_o)
);

// File: tb/tb_smbus_timeout_mon.sv
`timescale 1ns/1ps
module tb_smbus_timeout_mon;
    import smb_mon_pkg::*;

    localparam int HL_W = 8;
    localparam int LOW_TO = 60, HI_STD = 20, SEXT = 40, MEXT = 25;
    localparam int LMIN = 4, HMIN = 3, SUSTA = 4, SUSTO = 3;
    localparam int F_LO = 1, F_HI = 2, F_SE = 4, F_ME = 8, F_PE = 16, F_SU = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, hold_req = 1'b0, hi_sel = 1'b0, err_clr = 1'b0;
    logic [HL_W-1:0] lim_hi = '0, lim_lo = '0;
    logic in_msg, xact_rst;
    logic [NUM_ERR-1:0] flags;

    int checks = 0, fails = 0, xact_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smbus_timeout_mon #(
        .HL_W(HL_W), .LOW_TO_T(LOW_TO), .HIGH_STD_T(HI_STD), .SEXT_T(SEXT), .MEXT_T(MEXT),
        .LOW_MIN_T(LMIN), .HIGH_MIN_T(HMIN), .SU_STA_T(SUSTA), .SU_STO_T(SUSTO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .hold_req_i(hold_req),
        .hi_sel_i(hi_sel), .hi_lim_hi_i(lim_hi), .hi_lim_lo_i(lim_lo), .err_clr_i(err_clr),
        .in_msg_o(in_msg), .err_flags_o(flags), .xact_rst_o(xact_rst)
    );

    always @(negedge clk) if (rst_n && xact_rst) xact_cnt++;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected flags of a random message whose low phases all go to one budget
    function automatic int exp_budget(input bit tgt, input int sum);
        if (tgt) return (sum > SEXT) ? F_SE : 0;
        return (sum > MEXT) ? F_ME : 0;
    endfunction

    task automatic go_idle();
        hold_req = 1'b0; scl = 1'b1; cyc(2); sda = 1'b1; cyc(6);
    endtask

    task automatic start_msg(input int h);
        sda = 1'b0; cyc(h);
    endtask

    task automatic send_bit(input int l, input int h, input bit v, input bit hold);
        scl = 1'b0; hold_req = hold; cyc(1); sda = v; cyc(l - 1); scl = 1'b1; cyc(h);
    endtask

    task automatic rep_start(input int l, input int d, input int h, input bit hold);
        scl = 1'b0; hold_req = hold; cyc(1); sda = 1'b1; cyc(l - 1);
        scl = 1'b1; cyc(d); sda = 1'b0; cyc(h);
    endtask

    task automatic end_msg(input int l, input int d, input bit hold);
        scl = 1'b0; hold_req = hold; cyc(1); sda = 1'b0; cyc(l - 1);
        scl = 1'b1; cyc(d); sda = 1'b1; cyc(6);
    endtask

    task automatic clear_errs();
        err_clr = 1'b1; cyc(1); err_clr = 1'b0; cyc(2);
    endtask

    initial begin
        int prev;
        void'($urandom(32'd5150));
        cyc(5); rst_n = 1'b1; cyc(2);

        chk("R1 in_msg after reset", in_msg, 0);
        chk("R1 flags after reset", flags, 0);
        chk("R1 no reset pulse", xact_cnt, 0);

        start_msg(8);
        chk("R2 START opens message", in_msg, 1);
        send_bit(10, 8, 1'b1, 1'b0);
        end_msg(6, 5, 1'b0);
        chk("R2 STOP closes message", in_msg, 0);
        chk("R2 clean message no flags", flags, 0);

        scl = 1'b0; cyc(LOW_TO); scl = 1'b1; cyc(6);
        chk("R3 low of exactly limit", flags, 0);
        scl = 1'b0; cyc(LOW_TO + 1); scl = 1'b1; cyc(6);
        chk("R3 low over limit", flags, F_LO);
        chk("R10 first pulse", xact_cnt, 1);
        clear_errs();
        chk("R10 clear", flags, 0);

        cyc(100);
        chk("R4 idle high outside message", flags, 0);
        prev = xact_cnt;
        start_msg(30);
        chk("R4 high over standard limit", flags, F_HI);
        chk("R11 abort on high timeout", in_msg, 0);
        chk("R10 pulse on high timeout", xact_cnt - prev, 1);
        clear_errs(); go_idle();

        hi_sel = 1'b1; lim_hi = 8'd0; lim_lo = 8'd50;
        start_msg(30);
        chk("R5 programmable limit not reached", flags, 0);
        chk("R5 message still open", in_msg, 1);
        end_msg(6, 5, 1'b0);
        start_msg(60);
        chk("R5 programmable limit exceeded", flags, F_HI);
        clear_errs(); hi_sel = 1'b0; go_idle();

        start_msg(8);
        for (int i = 0; i < 4; i++) send_bit(10, 8, i[0], 1'b1);
        chk("R6 target budget at limit", flags, 0);
        send_bit(10, 8, 1'b0, 1'b1);
        chk("R6 target budget exceeded", flags, F_SE);
        clear_errs(); go_idle();

        start_msg(8);
        for (int i = 0; i < 3; i++) send_bit(10, 8, 1'b1, 1'b1);
        rep_start(10, 6, 8, 1'b0);
        send_bit(10, 8, 1'b0, 1'b1);
        chk("R6 sum kept across repeated START", flags, 0);
        send_bit(10, 8, 1'b0, 1'b1);
        chk("R6 repeated START does not clear sum", flags, F_SE);
        clear_errs(); go_idle();

        start_msg(8);
        for (int i = 0; i < 3; i++) send_bit(10, 8, 1'b1, 1'b1);
        chk("R6 new START clears sum", flags, 0);
        end_msg(6, 5, 1'b0);

        start_msg(8);
        send_bit(10, 8, 1'b1, 1'b0);
        send_bit(10, 8, 1'b0, 1'b0);
        chk("R7 controller budget under limit", flags, 0);
        send_bit(6, 8, 1'b1, 1'b0);
        chk("R7 controller budget exceeded", flags, F_ME);
        chk("R11 abort on budget", in_msg, 0);
        clear_errs(); go_idle();

        prev = xact_cnt;
        start_msg(8);
        send_bit(2, 8, 1'b1, 1'b0);
        chk("R8 short low phase", flags, F_PE);
        chk("R10 pulse on short low", xact_cnt - prev, 1);
        go_idle();
        scl = 1'b0; cyc(LOW_TO + 5); scl = 1'b1; cyc(6);
        chk("R10 second violation adds flag", flags, F_PE | F_LO);
        chk("R10 no pulse while flag pending", xact_cnt - prev, 1);
        cyc(50);
        chk("R10 flags stay set", flags, F_PE | F_LO);
        clear_errs();
        chk("R10 clear both", flags, 0);
        start_msg(8);
        send_bit(10, 2, 1'b0, 1'b0);
        send_bit(10, 8, 1'b0, 1'b0);
        chk("R8 short high phase", flags, F_PE);
        chk("R10 pulse again after clear", xact_cnt - prev, 2);
        clear_errs(); go_idle();

        start_msg(8);
        send_bit(10, 8, 1'b1, 1'b0);
        rep_start(10, 2, 8, 1'b0);
        chk("R9 repeated START setup too short", flags, F_SU);
        clear_errs(); go_idle();
        start_msg(8);
        send_bit(10, 8, 1'b1, 1'b0);
        end_msg(6, SUSTO, 1'b0);
        chk("R9 STOP setup at minimum", flags, 0);
        start_msg(8);
        send_bit(10, 8, 1'b1, 1'b0);
        end_msg(6, 1, 1'b0);
        chk("R9 STOP setup too short", flags, F_SU);
        clear_errs(); go_idle();

        for (int it = 0; it < 40; it++) begin
            bit tgt;
            int nb, sum, l, ex;
            tgt = 1'($urandom % 2);
            nb  = 1 + int'($urandom % 4);
            sum = 0;
            prev = xact_cnt;
            start_msg(8);
            for (int b = 0; b < nb; b++) begin
                l = 4 + int'($urandom % 9);
                send_bit(l, 3 + int'($urandom % 13), 1'($urandom % 2), tgt);
                sum += l;
            end
            l = 4 + int'($urandom % 9);
            end_msg(l, 5, tgt);
            sum += l;
            ex = exp_budget(tgt, sum);
            chk(tgt ? "R6 random target budget" : "R7 random controller budget", flags, ex);
            chk("R2 random message closed", in_msg, 0);
            chk("R10 random pulse count", xact_cnt - prev, (ex != 0) ? 1 : 0);
            clear_errs(); go_idle();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule